// File: doc/BRIEF.md
# Window Watchdog Timer

This block supervises software through a two-phase countdown. Once enabled, it first counts a closed window and then an open window. Each length is a count of clock cycles held in its own 32-bit register. Software proves it is alive by writing a restart request while the open window is running. That write reloads the closed window and starts a new round.

A restart that comes while the closed window is still running is treated as a fault. So is an open window that runs out with no restart. Either fault raises a reset output, and the output stays high until the block's own synchronous reset clears it.

Access is through a plain word-wide register bus: address, write strobe, write data, and combinational read data. The control register is guarded. Software must first open a one-shot write gate in a separate register. Any control write made while the gate is closed is dropped. The window registers are locked while the timer runs. An interrupt flag marks the start of each open window.

Top module: `win_watchdog`

## Requirements
- R1: After reset, every register reads 0, and both `wdt_reset_o` and `irq_o` are 0.
- R2: Writing to offset 0x04 (control) takes effect only while the gate bit (bit 0 at offset 0x00, readable) is 1. The gate bit drops to 0 after one accepted control write. A control write made with the gate closed is ignored.
- R3: The closed-window length at 0x08 and the open-window length at 0x0C accept writes only while the enable bit is 0. Both read back their stored value.
- R4: Setting enable (control bit 0) from 0 to 1 starts a closed window of N cycles, then an open window of M cycles. N and M come from the two length registers, and a length of 0 counts as 1 cycle.
- R5: The interrupt flag (control bit 16, also driven on `irq_o`) is set on the edge where the open window begins. An accepted control write with bit 16 set to 1 clears it. If both happen on the same edge, setting wins.
- R6: An accepted control write with bit 8 (restart) and bit 0 set, made while the timer runs in the open window, reloads the closed window. Bit 8 always reads 0.
- R7: A restart accepted during the closed window sets `wdt_reset_o` on that same edge.
- R8: If the last open-window cycle passes with no restart, `wdt_reset_o` is set on the following edge, N+M edges after the enabling write.
- R9: Once set, `wdt_reset_o` stays 1 until `rst_n` is applied. Clearing enable does not lower it.
- R10: A restart request written while enable is 0 has no effect.
- R11: Clearing enable before a fault stops the count, and no reset follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_we | input | 1 | Write strobe, one write per asserted cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| wdt_reset_o | output | 1 | Sticky reset request on a window fault |
| irq_o | output | 1 | Open-window interrupt flag |

## Verification
The hardest situation to reach is a restart that lands on an exact phase edge. One case is the last closed-window cycle, where a restart must trip the reset. Another is the last open-window cycle, where a restart must still be accepted.

Both cases need a gate write and then a control write to line up with a window count that the bench itself set. The directed sequences therefore load short windows and time the two writes to the exact edge.

After that, a seeded random stream uses window lengths from 0 to 7, random gate and control writes, and random idle gaps. This stream hits the boundary edges many times. A cycle-level reference model in the bench compares every output on every cycle.

// File: rtl/wwd_pkg.sv
// Package wwd_pkg: shared types and register layout for the window watchdog.
// Assumes a 32-bit data word, since the control fields sit at bits 0, 8 and 16.
package wwd_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_CLOSED = 2'd1,
        PH_OPEN   = 2'd2,
        PH_TRIP   = 2'd3
    } wwd_phase_e;

    localparam int OFS_GATE     = 0;
    localparam int OFS_CTRL     = 4;
    localparam int OFS_WIN_BASE = 8;
    localparam int NUM_WIN      = 2;

    localparam int EN_BIT   = 0;
    localparam int KICK_BIT = 8;
    localparam int IRQ_BIT  = 16;

endpackage

// File: rtl/wwd_bus_regs.sv
// Module wwd_bus_regs: register file of the window watchdog.
// Holds the one-shot write gate, the enable bit, the interrupt flag and the
// two window lengths. Turns accepted control writes into start, stop and
// restart pulses for the counter.
// Assumes at most one bus write per cycle; reads are combinational.
module wwd_bus_regs
    import wwd_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              open_start,
    output logic              gate_q,
    output logic              en_q,
    output logic              irq_q,
    output logic              start_pulse,
    output logic              stop_pulse,
    output logic              kick_pulse,
    output logic [DATA_W-1:0] closed_len,
    output logic [DATA_W-1:0] open_len
);

    logic               sel_gate;
    logic               sel_ctrl;
    logic [NUM_WIN-1:0] sel_win;
    logic               ctrl_ok;
    logic [DATA_W-1:0]  win_len [NUM_WIN];

    assign sel_gate = (bus_addr == ADDR_W'(OFS_GATE));
    assign sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
    assign ctrl_ok  = bus_we && sel_ctrl && gate_q;

    // Decode the effect of an accepted control write.
    always_comb begin
        start_pulse = ctrl_ok && bus_wdata[EN_BIT] && !en_q;
        stop_pulse  = ctrl_ok && !bus_wdata[EN_BIT] && en_q;
        kick_pulse  = ctrl_ok && bus_wdata[KICK_BIT] && bus_wdata[EN_BIT] && en_q;
    end

    // One-shot gate: set or cleared by its own register, consumed by a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gate_q <= 1'b0;
        else if (bus_we && sel_gate)
            gate_q <= bus_wdata[0];
        else if (ctrl_ok)
            gate_q <= 1'b0;
    end

    // Enable bit: follows bit 0 of every accepted control write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (ctrl_ok)
            en_q <= bus_wdata[EN_BIT];
    end

    // Interrupt flag: set at the start of an open window, write-1-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else if (open_start)
            irq_q <= 1'b1;
        else if (ctrl_ok && bus_wdata[IRQ_BIT])
            irq_q <= 1'b0;
    end

    // One length register per window, writable only while the timer is off.
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        logic [DATA_W-1:0] len_q;

        assign sel_win[g] = (bus_addr == ADDR_W'(OFS_WIN_BASE + 4 * g));
        assign win_len[g] = len_q;

        // Load the window length while the timer is disabled.
        always_ff @(posedge clk) begin
            if (!rst_n)
                len_q <= '0;
            else if (bus_we && sel_win[g] && !en_q)
                len_q <= bus_wdata;
        end
    end

    assign closed_len = win_len[0];
    assign open_len   = win_len[1];

    // Read multiplexer; the restart bit always reads 0.
    always_comb begin
        bus_rdata = '0;
        if (sel_gate) begin
            bus_rdata[0] = gate_q;
        end else if (sel_ctrl) begin
            bus_rdata[EN_BIT]  = en_q;
            bus_rdata[IRQ_BIT] = irq_q;
        end else begin
            for (int i = 0; i < NUM_WIN; i++)
                if (sel_win[i])
                    bus_rdata = win_len[i];
        end
    end

endmodule

// File: rtl/wwd_phase_counter.sv
// Module wwd_phase_counter: two-phase window counter.
// Runs the closed window and then the open window, judges restart requests
// and reports a fault. A length of zero counts as one cycle. Once it trips,
// it holds until reset.
// Assumes that start, stop and kick are never high together.
module wwd_phase_counter
    import wwd_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             kick,
    input  logic [CNT_W-1:0] closed_len,
    input  logic [CNT_W-1:0] open_len,
    output wwd_phase_e       phase,
    output logic             open_start,
    output logic             fault_evt
);

    wwd_phase_e       ph_q, ph_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    function automatic logic [CNT_W-1:0] load_of(input logic [CNT_W-1:0] len);
        return (len == '0) ? '0 : len - CNT_W'(1);
    endfunction

    // Next phase and count for the current request and count value.
    always_comb begin
        ph_d       = ph_q;
        cnt_d      = cnt_q;
        open_start = 1'b0;
        fault_evt  = 1'b0;
        case (ph_q)
            PH_IDLE: begin
                if (start) begin
                    ph_d  = PH_CLOSED;
                    cnt_d = load_of(closed_len);
                end
            end
            PH_CLOSED: begin
                if (stop) begin
                    ph_d = PH_IDLE;
                end else if (kick) begin
                    ph_d      = PH_TRIP;
                    fault_evt = 1'b1;
                end else if (cnt_q == '0) begin
                    ph_d       = PH_OPEN;
                    cnt_d      = load_of(open_len);
                    open_start = 1'b1;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            PH_OPEN: begin
                if (stop) begin
                    ph_d = PH_IDLE;
                end else if (kick) begin
                    ph_d  = PH_CLOSED;
                    cnt_d = load_of(closed_len);
                end else if (cnt_q == '0) begin
                    ph_d      = PH_TRIP;
                    fault_evt = 1'b1;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            default: begin
                ph_d = PH_TRIP;
            end
        endcase
    end

    // Phase and count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            ph_q  <= ph_d;
            cnt_q <= cnt_d;
        end
    end

    assign phase = ph_q;

endmodule

// File: rtl/wwd_fault_latch.sv
// Module wwd_fault_latch: holds the reset request after any window fault.
// Assumes fault_evt is a single-cycle pulse; the output clears only on rst_n.
module wwd_fault_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_evt,
    output logic reset_req
);

    // Sticky set on a fault event.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reset_req <= 1'b0;
        else if (fault_evt)
            reset_req <= 1'b1;
    end

endmodule

// File: rtl/win_watchdog.sv
// Module win_watchdog: top level of the window watchdog.
// Joins the register file, the phase counter and the fault latch.
// Assumes a simple synchronous register bus with combinational read data.
module win_watchdog
    import wwd_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdt_reset_o,
    output logic              irq_o
);

    logic              gate_open;
    logic              en_on;
    logic              irq_flag;
    logic              start_pulse;
    logic              stop_pulse;
    logic              kick_pulse;
    logic              open_start;
    logic              fault_evt;
    logic [DATA_W-1:0] closed_len;
    logic [DATA_W-1:0] open_len;
    wwd_phase_e        phase;

    wwd_bus_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_we      (bus_we),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .open_start  (open_start),
        .gate_q      (gate_open),
        .en_q        (en_on),
        .irq_q       (irq_flag),
        .start_pulse (start_pulse),
        .stop_pulse  (stop_pulse),
        .kick_pulse  (kick_pulse),
        .closed_len  (closed_len),
        .open_len    (open_len)
    );

    wwd_phase_counter #(
        .CNT_W (DATA_W)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_pulse),
        .stop       (stop_pulse),
        .kick       (kick_pulse),
        .closed_len (closed_len),
        .open_len   (open_len),
        .phase      (phase),
        .open_start (open_start),
        .fault_evt  (fault_evt)
    );

    wwd_fault_latch u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_evt (fault_evt),
        .reset_req (wdt_reset_o)
    );

    assign irq_o = irq_flag;

endmodule

// File: rtl/win_watchdog_checker.sv
// Module win_watchdog_checker: temporal properties of the window watchdog.
// Bound to every win_watchdog instance; it only observes signals.
module win_watchdog_checker
    import wwd_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              wdt_reset_o,
    input logic              irq_o,
    input wwd_phase_e        phase,
    input logic              kick_pulse,
    input logic              open_start,
    input logic              gate_open,
    input logic              en_on,
    input logic [DATA_W-1:0] closed_len,
    input logic [DATA_W-1:0] open_len
);

    AST_RESET_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset_o |=> wdt_reset_o) else $error("reset output dropped"); // R9

    AST_KICK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_CTRL)) |-> !bus_rdata[KICK_BIT]) else $error("restart bit read 1"); // R6

    AST_EARLY_KICK_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CLOSED && kick_pulse) |=> wdt_reset_o) else $error("early restart not trapped"); // R7

    AST_OPEN_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        open_start |=> irq_o) else $error("open window did not flag"); // R5

    AST_GATE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_CTRL) && gate_open) |=> !gate_open) else $error("gate stayed open"); // R2

    AST_WIN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (en_on && bus_we) |=> ($stable(closed_len) && $stable(open_len))) else $error("window changed while running"); // R3

    AST_IDLE_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !wdt_reset_o) |=> !wdt_reset_o) else $error("trip from idle"); // R11

endmodule

bind win_watchdog win_watchdog_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_rdata   (bus_rdata),
    .wdt_reset_o (wdt_reset_o),
    .irq_o       (irq_o),
    .phase       (phase),
    .kick_pulse  (kick_pulse),
    .open_start  (open_start),
    .gate_open   (gate_open),
    .en_on       (en_on),
    .closed_len  (closed_len),
    .open_len    (open_len)
);

// File: tb/win_watchdog_bench.sv
// Bench for win_watchdog: directed edge cases plus seeded random traffic.
// A cycle-level reference model is compared with the outputs on every cycle.
module win_watchdog_bench;

    localparam int AW = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          wdt_reset_o;
    logic          irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    win_watchdog #(.ADDR_W(AW), .DATA_W(DW)) u_win_watchdog (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_we      (bus_we),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .wdt_reset_o (wdt_reset_o),
        .irq_o       (irq_o)
    );

    // Reference model state; phase 0 idle, 1 closed, 2 open, 3 tripped.
    bit          m_gate, m_en, m_irq, m_fault;
    int          m_ph;
    logic [31:0] m_cnt, m_closed, m_open;

    function automatic logic [31:0] m_load(input logic [31:0] len);
        return (len == 0) ? 32'd0 : len - 32'd1;
    endfunction

    function automatic logic [31:0] m_read(input logic [3:0] a);
        logic [31:0] v = '0;
        case (a)
            4'h0: v[0] = m_gate;
            4'h4: begin v[0] = m_en; v[16] = m_irq; end
            4'h8: v = m_closed;
            4'hC: v = m_open;
            default: v = '0;
        endcase
        return v;
    endfunction

    // Model step on each clock edge.
    always @(posedge clk) begin
        bit ok, st, sp, kk, os;
        if (!rst_n) begin
            m_gate <= 0; m_en <= 0; m_irq <= 0; m_fault <= 0;
            m_ph <= 0; m_cnt <= 0; m_closed <= 0; m_open <= 0;
        end else begin
            ok = bus_we && bus_addr == 4'h4 && m_gate;
            st = ok && bus_wdata[0] && !m_en;
            sp = ok && !bus_wdata[0] && m_en;
            kk = ok && bus_wdata[8] && bus_wdata[0] && m_en;
            os = 0;
            if (bus_we && bus_addr == 4'h0) m_gate <= bus_wdata[0];
            else if (ok) m_gate <= 0;
            if (ok) m_en <= bus_wdata[0];
            if (bus_we && bus_addr == 4'h8 && !m_en) m_closed <= bus_wdata;
            if (bus_we && bus_addr == 4'hC && !m_en) m_open <= bus_wdata;
            case (m_ph)
                0: if (st) begin m_ph <= 1; m_cnt <= m_load(m_closed); end
                1: if (sp) m_ph <= 0;
                   else if (kk) begin m_ph <= 3; m_fault <= 1; end
                   else if (m_cnt == 0) begin m_ph <= 2; m_cnt <= m_load(m_open); os = 1; end
                   else m_cnt <= m_cnt - 1;
                2: if (sp) m_ph <= 0;
                   else if (kk) begin m_ph <= 1; m_cnt <= m_load(m_closed); end
                   else if (m_cnt == 0) begin m_ph <= 3; m_fault <= 1; end
                   else m_cnt <= m_cnt - 1;
                default: m_ph <= 3;
            endcase
            if (os) m_irq <= 1;
            else if (ok && bus_wdata[16]) m_irq <= 0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison with the model, taken between edges.
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk("R8 model wdt_reset_o", 32'(wdt_reset_o), 32'(m_fault));
            chk("R5 model irq_o", 32'(irq_o), 32'(m_irq));
            chk("R2 model bus_rdata", bus_rdata, m_read(bus_addr));
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    // Watchdog of the bench itself.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        idle(1);
        do_reset();

        // R1: reset state
        for (int a = 0; a < 16; a += 4) begin
            rd(4'(a), v);
            chk("R1 register reset value", v, 0);
        end
        chk("R1 reset output", 32'(wdt_reset_o), 0);
        chk("R1 irq", 32'(irq_o), 0);

        // R2: control write without the gate is dropped
        wr(4'h4, 32'h1);
        rd(4'h4, v); chk("R2 ungated write ignored", v, 0);
        idle(20);    chk("R2 no run after ungated write", 32'(wdt_reset_o), 0);

        // R10: restart while disabled has no effect; R2 gate is one-shot
        wr(4'h0, 32'h1);
        rd(4'h0, v); chk("R2 gate reads open", v, 1);
        wr(4'h4, 32'h100);
        rd(4'h0, v); chk("R2 gate closes after use", v, 0);
        rd(4'h4, v); chk("R10 disabled restart ignored", v, 0);
        idle(10);    chk("R10 no fault after disabled restart", 32'(wdt_reset_o), 0);

        // R4, R5, R8: closed=5, open=4, enable at edge E
        wr(4'h8, 32'd5); wr(4'hC, 32'd4);
        rd(4'h8, v); chk("R3 closed length readback", v, 5);
        rd(4'hC, v); chk("R3 open length readback", v, 4);
        wr(4'h0, 32'h1);
        wr(4'h4, 32'h1);
        idle(4); chk("R4 irq low in last closed cycle", 32'(irq_o), 0);
        idle(1); chk("R4 irq high after N cycles", 32'(irq_o), 1);
        idle(3); chk("R8 no reset in last open cycle", 32'(wdt_reset_o), 0);
        idle(1); chk("R8 reset after open expiry", 32'(wdt_reset_o), 1);
        wr(4'h0, 32'h1); wr(4'h4, 32'h0);
        idle(5); chk("R9 reset held after disable", 32'(wdt_reset_o), 1);
        do_reset();
        chk("R9 reset cleared by rst_n", 32'(wdt_reset_o), 0);

        // R4: zero lengths act as one cycle
        wr(4'h0, 32'h1); wr(4'h4, 32'h1);
        chk("R4 zero length closed start", 32'(irq_o), 0);
        idle(1); chk("R4 zero length opens after 1", 32'(irq_o), 1);
        chk("R4 zero length no early trip", 32'(wdt_reset_o), 0);
        idle(1); chk("R8 zero length open expires", 32'(wdt_reset_o), 1);
        do_reset();

        // R6, R5, R7: closed=3, open=6
        wr(4'h8, 32'd3); wr(4'hC, 32'd6);
        wr(4'h0, 32'h1); wr(4'h4, 32'h1);
        idle(3);
        wr(4'h0, 32'h1); wr(4'h4, 32'h101);
        chk("R6 open restart no reset", 32'(wdt_reset_o), 0);
        rd(4'h4, v); chk("R6 restart bit reads 0", v, 32'h0001_0001);
        wr(4'h0, 32'h1); wr(4'h4, 32'h1_0001);
        chk("R5 irq cleared by write 1", 32'(irq_o), 0);
        idle(1); chk("R6 reload gives new open window", 32'(irq_o), 1);
        wr(4'h0, 32'h1); wr(4'h4, 32'h101);
        wr(4'h0, 32'h1);
        chk("R7 no reset before early restart", 32'(wdt_reset_o), 0);
        wr(4'h4, 32'h101);
        chk("R7 early restart trips", 32'(wdt_reset_o), 1);
        do_reset();

        // R11, R3: stop while running, windows locked while on
        wr(4'h8, 32'd20); wr(4'hC, 32'd20);
        wr(4'h0, 32'h1); wr(4'h4, 32'h1);
        wr(4'h8, 32'd99);
        rd(4'h8, v); chk("R3 locked while enabled", v, 20);
        wr(4'h0, 32'h1); wr(4'h4, 32'h0);
        idle(60);
        chk("R11 no reset after stop", 32'(wdt_reset_o), 0);
        chk("R11 no irq after stop", 32'(irq_o), 0);
        wr(4'h8, 32'd7);
        rd(4'h8, v); chk("R3 writable when disabled", v, 7);

        // Random traffic checked against the model every cycle
        for (int i = 0; i < 4000; i++) begin
            int sel = $urandom_range(0, 99);
            if (m_fault && $urandom_range(0, 7) == 0) begin
                do_reset();
            end else if (sel < 35) begin
                wr(4'h0, 32'($urandom_range(0, 3) != 0));
            end else if (sel < 65) begin
                logic [31:0] d = '0;
                d[0]  = ($urandom_range(0, 4) != 0);
                d[8]  = $urandom_range(0, 1);
                d[16] = $urandom_range(0, 1);
                wr(4'h4, d);
            end else if (sel < 80) begin
                wr(($urandom_range(0, 1) != 0) ? 4'h8 : 4'hC, 32'($urandom_range(0, 7)));
            end else if (sel < 85) begin
                wr(4'($urandom_range(0, 15)), $urandom);
            end else begin
                bus_addr = 4'($urandom_range(0, 3) * 4);
                idle($urandom_range(1, 6));
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule